// File: doc/BRIEF.md
# Oscillator Frequency Acquisition Controller

This block drives the tuning word of a digitally controlled oscillator so that the oscillator settles onto a target frequency. Once per reference cycle, a phase-frequency comparator outside the block raises `ref_tick` and presents three things: whether the oscillator is running too fast or too slow, and how large the frequency error is. The controller answers by moving the tuning word.

The controller runs through three modes in turn. First it presets the tuning word to a programmed starting value. Then it acquires the target frequency, using a step that adapts to the size of the error. Finally it tracks the locked frequency with single-LSB corrections. During acquisition the step comes from the error magnitude, and the previous gain is averaged with the new one. Large errors are therefore closed in a few large moves, and the average damps overshoot near the target. This takes the place of a fixed binary search, and it aims to lock within 18 reference cycles.

If the error grows well beyond the lock band while the controller is tracking, it drops lock and acquires again, starting from the current word.

Top module: `dco_acq_ctrl`

## Requirements
- R1: After reset the mode is calibration (code 0), the tuning word is 0 and the lock flag is low.
- R2: The first `ref_tick` in calibration loads the tuning word with `preset_word` and moves the mode to acquisition (code 1).
- R3: In acquisition the new gain is the error magnitude shifted right by one, clamped to the range 1 to 128.
- R4: The applied acquisition step is the floor of the average of the previous gain and the new gain. On the first acquisition tick after calibration or after an unlock, the new gain is used alone.
- R5: When only `slow` is high the step is added. When only `fast` is high it is subtracted. When both or neither are high the word is held. The gain history still updates on a held tick.
- R6: The tuning word saturates at 0 and at 1023 and never wraps.
- R7: After two consecutive acquisition ticks with the error at or below `lock_thr`, the mode becomes tracking (code 2) and `locked` goes high. The step is still applied on both of those ticks. An out-of-band tick resets the run.
- R8: In tracking, each tick moves the word by exactly one LSB in the direction given by R5.
- R9: In tracking, an error strictly greater than four times `lock_thr` clears `locked` and returns the mode to acquisition with the word unchanged. An error equal to four times the threshold keeps lock.
- R10: Without `ref_tick`, the mode, the lock flag and the tuning word do not change, whatever the other inputs are.
- R11: In a closed loop with an oscillator whose error is the word distance to the target, clipped to 255, a start 600 codes from the target reaches lock within 18 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | One-cycle strobe marking a valid comparator result |
| fast | input | 1 | Oscillator is above the target |
| slow | input | 1 | Oscillator is below the target |
| err_mag | input | 8 | Frequency error magnitude |
| preset_word | input | 10 | Tuning word loaded in calibration |
| lock_thr | input | 8 | Error at or below which a tick counts toward lock |
| tune_word | output | 10 | Oscillator tuning word |
| mode | output | 2 | 0 calibration, 1 acquisition, 2 tracking |
| locked | output | 1 | High while tracking |

## Verification
The bench builds the controller with its default parameters: a 10-bit word, an 8-bit error, a gain shift of one, gain bounds of 1 and 128, a two-tick lock run and a fourfold unlock margin. With these values both saturation rails and the lower gain clamp can be reached with single large or tiny errors. Lock thresholds of 0 and 2 are programmed. The threshold of 2 puts the unlock boundary at an error of exactly 8, so the kept and dropped cases sit one code apart. A closed-loop oscillator model in the bench then shows the blended gain converging from 600 codes away.

// File: rtl/dco_acq_pkg.sv
package dco_acq_pkg;

  typedef enum logic [1:0] {
    MODE_CAL = 2'd0,
    MODE_ACQ = 2'd1,
    MODE_TRK = 2'd2
  } acq_mode_e;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } step_dir_e;

  // Comparator flags to a step direction; contradictory or absent flags hold.
  function automatic step_dir_e decode_dir(input logic is_fast, input logic is_slow);
    step_dir_e d;
    if (is_slow && !is_fast)      d = DIR_UP;
    else if (is_fast && !is_slow) d = DIR_DOWN;
    else                          d = DIR_HOLD;
    return d;
  endfunction

endpackage

// File: rtl/dco_gain_gen.sv
module dco_gain_gen #(
  parameter int ERR_W    = 8,
  parameter int GAIN_W   = 8,
  parameter int SHIFT    = 1,
  parameter int GAIN_MIN = 1,
  parameter int GAIN_MAX = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clear,
  input  logic [ERR_W-1:0]  err,
  output logic [GAIN_W-1:0] step
);

  localparam int CW = ((ERR_W > GAIN_W) ? ERR_W : GAIN_W) + 1;

  logic [CW-1:0]     shifted;
  logic [GAIN_W-1:0] gain_new;
  logic [GAIN_W:0]   blend_sum;
  logic [GAIN_W-1:0] prev_q, prev_d;
  logic              have_prev_q, have_prev_d;

  // New gain from the error magnitude, clamped to the legal gain range.
  always_comb begin
    shifted = CW'(err) >> SHIFT;
    if (shifted < CW'(GAIN_MIN))      gain_new = GAIN_W'(GAIN_MIN);
    else if (shifted > CW'(GAIN_MAX)) gain_new = GAIN_W'(GAIN_MAX);
    else                              gain_new = shifted[GAIN_W-1:0];
  end

  // Blend with the gain of the previous tick, unless the history is empty.
  always_comb begin
    blend_sum = {1'b0, prev_q} + {1'b0, gain_new};
    if (have_prev_q) step = blend_sum[GAIN_W:1];
    else             step = gain_new;
  end

  always_comb begin
    prev_d      = prev_q;
    have_prev_d = have_prev_q;
    if (clear) begin
      have_prev_d = 1'b0;
    end else if (en) begin
      prev_d      = gain_new;
      have_prev_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else begin
      prev_q      <= prev_d;
      have_prev_q <= have_prev_d;
    end
  end

  // R3: whatever the history, the applied step stays within the gain bounds.
  a_r3_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (step >= GAIN_W'(GAIN_MIN)) && (step <= GAIN_W'(GAIN_MAX)));

  // R4: after a clear, the next tick sees no history.
  a_r4_clear_empties_history: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !have_prev_q);

endmodule

// File: rtl/dco_step_unit.sv
module dco_step_unit
  import dco_acq_pkg::*;
#(
  parameter int TW_W   = 10,
  parameter int STEP_W = 8
) (
  input  logic [TW_W-1:0]   word_in,
  input  logic [STEP_W-1:0] step,
  input  step_dir_e         dir,
  output logic [TW_W-1:0]   word_out
);

  localparam int SW = ((TW_W > STEP_W) ? TW_W : STEP_W) + 1;
  localparam logic [SW-1:0] TOP = SW'((64'd1 << TW_W) - 64'd1);

  logic [SW-1:0] w_ext, s_ext, up_sum;

  always_comb begin
    w_ext  = SW'(word_in);
    s_ext  = SW'(step);
    up_sum = w_ext + s_ext;
    case (dir)
      DIR_UP:   word_out = (up_sum > TOP) ? TOP[TW_W-1:0] : up_sum[TW_W-1:0];
      DIR_DOWN: word_out = (s_ext > w_ext) ? '0 : TW_W'(w_ext - s_ext);
      default:  word_out = word_in;
    endcase
  end

endmodule

// File: rtl/dco_lock_detect.sv
module dco_lock_detect #(
  parameter int ERR_W        = 8,
  parameter int LOCK_RUN     = 2,
  parameter int UNLOCK_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_tick,
  input  logic             trk_tick,
  input  logic             clear,
  input  logic [ERR_W-1:0] err,
  input  logic [ERR_W-1:0] thr,
  output logic             lock_hit,
  output logic             lose_lock,
  output logic             locked
);

  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int WW    = ERR_W + UNLOCK_SHIFT;

  logic [RUN_W-1:0] run_q, run_d;
  logic             locked_d;
  logic             in_band;
  logic [WW-1:0]    wide_thr;

  always_comb begin
    in_band   = (err <= thr);
    wide_thr  = WW'(thr) << UNLOCK_SHIFT;
    lock_hit  = acq_tick && in_band && (run_q == RUN_W'(LOCK_RUN - 1));
    lose_lock = trk_tick && (WW'(err) > wide_thr);
  end

  always_comb begin
    run_d    = run_q;
    locked_d = locked;
    if (clear) begin
      run_d    = '0;
      locked_d = 1'b0;
    end else if (acq_tick) begin
      if (!in_band || lock_hit) run_d = '0;
      else                      run_d = run_q + RUN_W'(1);
      if (lock_hit) locked_d = 1'b1;
    end else if (lose_lock) begin
      run_d    = '0;
      locked_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      locked <= 1'b0;
    end else begin
      run_q  <= run_d;
      locked <= locked_d;
    end
  end

  // R7: an out-of-band acquisition tick restarts the qualifying run.
  a_r7_run_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_tick && !in_band) |=> (run_q == '0));

  // R9: losing lock always clears the flag on the next cycle.
  a_r9_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
    lose_lock |=> !locked);

endmodule

// File: rtl/dco_acq_ctrl.sv
module dco_acq_ctrl
  import dco_acq_pkg::*;
#(
  parameter int TW_W         = 10,
  parameter int ERR_W        = 8,
  parameter int GAIN_SHIFT   = 1,
  parameter int GAIN_MIN     = 1,
  parameter int GAIN_MAX     = 128,
  parameter int LOCK_RUN     = 2,
  parameter int UNLOCK_SHIFT = 2,
  parameter int TRK_STEP     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              fast,
  input  logic              slow,
  input  logic [ERR_W-1:0]  err_mag,
  input  logic [TW_W-1:0]   preset_word,
  input  logic [ERR_W-1:0]  lock_thr,
  output logic [TW_W-1:0]   tune_word,
  output logic [1:0]        mode,
  output logic              locked
);

  localparam int GAIN_W = $clog2(GAIN_MAX + 1);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acq_mode_e         mode_q, mode_d;
  logic [TW_W-1:0]   tw_q, tw_d;
  logic [GAIN_W-1:0] acq_step, applied_step;
  logic [TW_W-1:0]   stepped_word;
  step_dir_e         dir;
  logic              acq_tick, trk_tick, cal_tick;
  logic              lock_hit, lose_lock, lock_flag;
  logic              gain_clear;

  always_comb begin
    dir        = decode_dir(fast, slow);
    cal_tick   = ref_tick && (mode_q == MODE_CAL);
    acq_tick   = ref_tick && (mode_q == MODE_ACQ);
    trk_tick   = ref_tick && (mode_q == MODE_TRK);
    gain_clear = cal_tick || lose_lock;
  end

  dco_gain_gen #(
    .ERR_W    (ERR_W),
    .GAIN_W   (GAIN_W),
    .SHIFT    (GAIN_SHIFT),
    .GAIN_MIN (GAIN_MIN),
    .GAIN_MAX (GAIN_MAX)
  ) u_gain (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (acq_tick),
    .clear (gain_clear),
    .err   (err_mag),
    .step  (acq_step)
  );

  dco_lock_detect #(
    .ERR_W        (ERR_W),
    .LOCK_RUN     (LOCK_RUN),
    .UNLOCK_SHIFT (UNLOCK_SHIFT)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acq_tick  (acq_tick),
    .trk_tick  (trk_tick),
    .clear     (cal_tick),
    .err       (err_mag),
    .thr       (lock_thr),
    .lock_hit  (lock_hit),
    .lose_lock (lose_lock),
    .locked    (lock_flag)
  );

  // One saturating adder serves both search schemes; only the step differs.
  always_comb begin
    if (mode_q == MODE_TRK) applied_step = GAIN_W'(TRK_STEP);
    else                    applied_step = acq_step;
  end

  dco_step_unit #(
    .TW_W   (TW_W),
    .STEP_W (GAIN_W)
  ) u_step (
    .word_in  (tw_q),
    .step     (applied_step),
    .dir      (dir),
    .word_out (stepped_word)
  );

  always_comb begin
    mode_d = mode_q;
    tw_d   = tw_q;
    case (mode_q)
      MODE_CAL: if (ref_tick) begin
        tw_d   = preset_word;
        mode_d = MODE_ACQ;
      end
      MODE_ACQ: if (ref_tick) begin
        tw_d = stepped_word;
        if (lock_hit) mode_d = MODE_TRK;
      end
      MODE_TRK: if (ref_tick) begin
        if (lose_lock) mode_d = MODE_ACQ;
        else           tw_d   = stepped_word;
      end
      default: mode_d = MODE_CAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= MODE_CAL;
      tw_q   <= '0;
    end else begin
      mode_q <= mode_d;
      tw_q   <= tw_d;
    end
  end

  assign tune_word = tw_q;
  assign mode      = mode_q;
  assign locked    = lock_flag;

  // R10: nothing moves between comparator strobes.
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ref_tick |=> $stable(tune_word) && $stable(mode) && $stable(locked));

  // R2: calibration loads the preset and hands over to acquisition.
  a_r2_cal_preset: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_q == MODE_CAL && ref_tick) |=>
      (mode_q == MODE_ACQ) && (tune_word == $past(preset_word)));

  // R7: the lock flag and the tracking mode agree.
  a_r7_flag_matches_mode: assert property (@(posedge clk) disable iff (!rst_int_n)
    locked == (mode_q == MODE_TRK));

  // R8: tracking never moves the word by more than one code.
  a_r8_track_unit_step: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_q == MODE_TRK && ref_tick) |=>
      (tune_word == $past(tune_word)) ||
      (tune_word == $past(tune_word) + TW_W'(1)) ||
      (tune_word + TW_W'(1) == $past(tune_word)));

  // R5: a slow-only acquisition tick never lowers the word.
  a_r5_slow_not_down: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_q == MODE_ACQ && ref_tick && slow && !fast) |=> (tune_word >= $past(tune_word)));

  // R5: contradictory flags hold the word.
  a_r5_both_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_q != MODE_CAL && ref_tick && slow && fast) |=> $stable(tune_word));

endmodule

// File: tb/dco_acq_ctrl_bench.sv
module dco_acq_ctrl_bench;

  logic       clk;
  logic       rst_n;
  logic       ref_tick;
  logic       fast;
  logic       slow;
  logic [7:0] err_mag;
  logic [9:0] preset_word;
  logic [7:0] lock_thr;
  logic [9:0] tune_word;
  logic [1:0] mode;
  logic       locked;

  dco_acq_ctrl u_dco_acq_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_tick    (ref_tick),
    .fast        (fast),
    .slow        (slow),
    .err_mag     (err_mag),
    .preset_word (preset_word),
    .lock_thr    (lock_thr),
    .tune_word   (tune_word),
    .mode        (mode),
    .locked      (locked)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Scoreboard queues: expected {mode, locked, word} and the requirement tag.
  logic [12:0] exp_q[$];
  string       tag_q[$];
  bit          mon_en = 1'b0;

  // Reference model state.
  int m_mode, m_tw, m_prev, m_cnt, m_thr, m_preset;
  bit m_first, m_locked;

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got mode=%0d lock=%0d word=%0d, expected mode=%0d lock=%0d word=%0d",
               tag, act[12:11], act[10], act[9:0], exp[12:11], exp[10], exp[9:0]);
    end
  endtask

  function automatic logic [12:0] model_word();
    return {2'(m_mode), m_locked, 10'(m_tw)};
  endfunction

  // Monitor: compares the design after each edge against the oldest expectation.
  always @(posedge clk) begin
    if (mon_en && rst_n) begin
      #2;
      if (exp_q.size() > 0) begin
        check(tag_q.pop_front(), {mode, locked, tune_word}, exp_q.pop_front());
      end
    end
  end

  task automatic model_tick(input bit f, input bit s, input int e);
    int g, st;
    case (m_mode)
      0: begin
        m_tw = m_preset; m_mode = 1; m_first = 1; m_cnt = 0;
      end
      1: begin
        g = e >> 1;
        if (g < 1) g = 1;
        if (g > 128) g = 128;
        st = m_first ? g : (m_prev + g) / 2;
        if (s && !f) m_tw = (m_tw + st > 1023) ? 1023 : m_tw + st;
        else if (f && !s) m_tw = (m_tw - st < 0) ? 0 : m_tw - st;
        m_prev = g; m_first = 0;
        if (e <= m_thr) begin
          m_cnt++;
          if (m_cnt >= 2) begin m_mode = 2; m_locked = 1; m_cnt = 0; end
        end else m_cnt = 0;
      end
      default: begin
        if (e > 4 * m_thr) begin
          m_mode = 1; m_locked = 0; m_first = 1; m_cnt = 0;
        end else if (s && !f) m_tw = (m_tw == 1023) ? 1023 : m_tw + 1;
        else if (f && !s) m_tw = (m_tw == 0) ? 0 : m_tw - 1;
      end
    endcase
  endtask

  // Driver: applies one cycle of stimulus at a falling edge and queues the result.
  task automatic drive(input bit tk, input bit f, input bit s, input int e, input string tag);
    ref_tick = tk; fast = f; slow = s; err_mag = 8'(e);
    if (tk) model_tick(f, s, e);
    exp_q.push_back(model_word());
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic do_reset(input int pre, input int thr);
    mon_en = 1'b0;
    exp_q.delete(); tag_q.delete();
    ref_tick = 0; fast = 0; slow = 0; err_mag = 0;
    preset_word = 10'(pre); lock_thr = 8'(thr);
    m_preset = pre; m_thr = thr;
    m_mode = 0; m_tw = 0; m_prev = 0; m_cnt = 0; m_first = 1; m_locked = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", {mode, locked, tune_word}, 13'd0);
    mon_en = 1'b1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, got hang, expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b1;
    @(negedge clk);
    do_reset(100, 2);

    // R10: idle cycles with active-looking inputs change nothing.
    drive(0, 0, 1, 255, "R10 idle before calibration");
    drive(0, 1, 0, 255, "R10 idle before calibration");
    // R2: calibration tick loads the preset.
    drive(1, 0, 1, 255, "R2 preset load");
    // R3/R4: first tick uses new gain alone: 100+127.
    drive(1, 0, 1, 255, "R4 first acquisition step");
    drive(0, 1, 0, 200, "R10 idle in acquisition");
    // R3: error 0 clamps gain to 1; blend (127+1)/2 = 64.
    drive(1, 0, 1, 0, "R3 lower clamp and blend");
    drive(1, 1, 0, 40, "R5 fast subtracts");
    drive(1, 1, 1, 50, "R5 both flags hold");
    drive(1, 0, 0, 10, "R5 no flag holds");
    drive(1, 0, 1, 2, "R7 first in-band tick");
    drive(1, 0, 1, 9, "R7 run broken");
    drive(1, 1, 0, 2, "R7 run restart");
    drive(1, 0, 1, 1, "R7 lock declared");
    // Tracking.
    drive(1, 0, 1, 3, "R8 track up");
    drive(1, 1, 0, 8, "R9 boundary keeps lock");
    drive(1, 1, 1, 0, "R8 track hold");
    drive(0, 0, 1, 255, "R10 idle in tracking");
    drive(1, 0, 1, 9, "R9 unlock");
    drive(1, 0, 1, 200, "R4 fresh history after unlock");
    @(negedge clk);

    // R6: top rail.
    do_reset(1000, 0);
    drive(1, 0, 0, 0, "R2 preset load high");
    drive(1, 0, 1, 255, "R6 saturate at 1023");
    drive(1, 0, 1, 255, "R6 stay at 1023");
    @(negedge clk);

    // R6: bottom rail.
    do_reset(50, 0);
    drive(1, 0, 0, 0, "R2 preset load low");
    drive(1, 1, 0, 255, "R6 saturate at 0");
    @(negedge clk);

    // R11: closed loop from 600 codes away.
    do_reset(100, 2);
    drive(1, 0, 0, 0, "R2 preset load loop");
    for (int i = 0; i < 18; i++) begin
      int diff, e;
      if (m_locked) break;
      diff = m_tw - 700;
      e = (diff < 0) ? -diff : diff;
      if (e > 255) e = 255;
      drive(1, diff > 0, diff < 0, e, "R11 closed-loop step");
    end
    @(negedge clk);
    check("R11 lock within 18 ticks", {12'd0, locked}, 13'd1);

    mon_en = 1'b0;
    finish_run();
  end

endmodule